// File: doc/BRIEF.md
# Prioritised Interrupt Dispatcher with Transfer-Server Hand-Back

This block decides which of sixteen interrupt sources the core services next. Each source either goes to an ordinary service routine or to a hardware transfer server. The choice depends on a per-source transfer-select bit. Every source also has an 8-bit transfer count. A separate strobe from the transfer server decrements that count each time a transfer finishes. When the count runs out, the block takes the source away from the transfer server. It then raises an end-of-transfer interrupt for that source. That interrupt uses the source's ordinary vector and has the source's ordinary priority.

Dispatch is timed against the core's instruction boundaries. A request that becomes eligible near the end of an instruction is not acknowledged at that instruction's boundary. It waits for the boundary after it. Each dispatch is a one-cycle pulse that carries the source number, a transfer/ordinary flag and a 24-bit vector address.

Top module: `irq_dispatch_top`

## Requirements
- R1: A request pulse on `req_in[i]` sets a pending bit that stays set while the source is blocked. A source is blocked when `src_en[i]` is 0 or `glob_en` is 0. A blocked source is never dispatched, and it is dispatched once it is unblocked.
- R2: Among eligible sources, the highest index wins.
- R3: The ordinary vector of source i is 0xFF2000 + 2*i. The transfer vector of source i is 0xFF2040 + 2*i. For example, source 4 uses 0xFF2008 (ordinary) and 0xFF2048 (transfer).
- R4: A pending request of a source whose transfer-select bit is set dispatches with `disp_xfer`=1 and the transfer vector. Otherwise it dispatches with `disp_xfer`=0.
- R5: A strobe on `xfer_done` for source i that takes its count from 1 to 0 has two effects, visible the cycle after the strobe. It clears `xsel_q[i]` and sets `eot_q[i]`. A strobe that leaves a nonzero count changes neither bit.
- R6: A set `eot_q[i]` makes source i eligible with its own index priority. It dispatches with `disp_xfer`=0 and the ordinary vector, and that dispatch clears `eot_q[i]`. The end-of-transfer request is served before any ordinary request of the same source.
- R7: A write on `sel_wr` loads the whole transfer-select register from `sel_wdata`. This is how software hands a source back to the transfer server.
- R8: A dispatch happens only on an `instr_end` cycle. `disp_valid` rises in the cycle after that boundary and stays high for exactly one cycle.
- R9: A source can become eligible while `states_left` is 4 or less. In that case the first `instr_end` after that point is skipped, and the dispatch follows the second one. With `states_left` of 5 or more, the first boundary dispatches.
- R10: After reset, `disp_valid`, `xsel_q` and `eot_q` are all zero.
- R11: A transfer strobe on a source whose count is already zero leaves `xsel_q` and `eot_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 16 | Per-source request pulses |
| src_en | input | 16 | Per-source enable mask |
| glob_en | input | 1 | Global interrupt enable |
| sel_wr | input | 1 | Write strobe for the transfer-select register |
| sel_wdata | input | 16 | New transfer-select value |
| cnt_wr | input | 1 | Write strobe for one transfer count |
| cnt_idx | input | 4 | Source whose count is written |
| cnt_wdata | input | 8 | Count value to load |
| xfer_done | input | 1 | One transfer completed |
| xfer_idx | input | 4 | Source the completed transfer belongs to |
| instr_end | input | 1 | Current instruction or uninterruptible sequence completes |
| states_left | input | 4 | State times left in the current instruction |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_idx | output | 4 | Dispatched source |
| disp_xfer | output | 1 | 1 = transfer server, 0 = ordinary routine |
| disp_vec | output | 24 | Vector address |
| xsel_q | output | 16 | Current transfer-select register |
| eot_q | output | 16 | End-of-transfer pending bits |

## Verification
The hardest situation to reach from the ports is a source that has just been handed back. Its end-of-transfer bit is pending while an ordinary request from a lower source competes with it. The bench reaches this in three steps. It loads a small count and routes the source to the transfer server. It then issues exactly enough completion strobes to drain the count, and raises the lower source before the next boundary. A second hard case is the late-arrival skip. The bench holds `states_left` at the threshold value and at one above it while a request becomes eligible. It then counts the boundaries that pass before the dispatch pulse appears.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int NSRC      = 16;
    localparam int CNT_W     = 8;
    localparam int VEC_W     = 24;
    localparam int ST_W      = 4;
    localparam int LATE_WIN  = 4;
    localparam int VEC_STEP  = 2;
    localparam logic [VEC_W-1:0] STD_BASE  = 24'hFF2000;
    localparam logic [VEC_W-1:0] XFER_BASE = 24'hFF2040;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_NEXT = 2'd1,
        ACK_SKIP = 2'd2
    } ack_state_e;

    typedef enum logic {
        KIND_STD  = 1'b0,
        KIND_XFER = 1'b1
    } kind_e;

    typedef struct packed {
        logic  found;
        logic  eot;
        kind_e kind;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx, input kind_e k);
        logic [VEC_W-1:0] base;
        base = (k == KIND_XFER) ? XFER_BASE : STD_BASE;
        return base + VEC_W'(idx * VEC_STEP);
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_dispatch_pkg::*;
#(
    parameter int N   = NSRC,
    parameter int CW  = CNT_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_in,
    input  logic          sel_wr,
    input  logic [N-1:0]  sel_wdata,
    input  logic          cnt_wr,
    input  logic [IW-1:0] cnt_idx,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          xfer_done,
    input  logic [IW-1:0] xfer_idx,
    input  logic          take_valid,
    input  logic [IW-1:0] take_idx,
    input  logic          take_eot,
    output logic [N-1:0]  req_pend,
    output logic [N-1:0]  eot_pend,
    output logic [N-1:0]  sel_q
);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic [CW-1:0] count;
        logic          wr_hit;
        logic          done_hit;
        logic          take_hit;
        logic          drain;

        assign wr_hit   = cnt_wr && (cnt_idx == IW'(i));
        assign done_hit = xfer_done && (xfer_idx == IW'(i));
        assign take_hit = take_valid && (take_idx == IW'(i));
        assign drain    = done_hit && !wr_hit && (count == CW'(1));

        always_ff @(posedge clk) begin
            if (rst)
                count <= '0;
            else if (wr_hit)
                count <= cnt_wdata;
            else if (done_hit && count != '0)
                count <= count - CW'(1);
        end

        always_ff @(posedge clk) begin
            if (rst)
                sel_q[i] <= 1'b0;
            else if (drain)
                sel_q[i] <= 1'b0;
            else if (sel_wr)
                sel_q[i] <= sel_wdata[i];
        end

        always_ff @(posedge clk) begin
            if (rst)
                eot_pend[i] <= 1'b0;
            else if (drain)
                eot_pend[i] <= 1'b1;
            else if (take_hit && take_eot)
                eot_pend[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                req_pend[i] <= 1'b0;
            else if (req_in[i])
                req_pend[i] <= 1'b1;
            else if (take_hit && !take_eot)
                req_pend[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_dispatch_pkg::*;
#(
    parameter int N   = NSRC,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_pend,
    input  logic [N-1:0]  eot_pend,
    input  logic [N-1:0]  sel_q,
    input  logic [N-1:0]  src_en,
    input  logic          glob_en,
    output pick_t         pick,
    output logic [IW-1:0] pick_idx
);

    logic [N-1:0] eligible;

    assign eligible = (req_pend | eot_pend) & src_en & {N{glob_en}};

    always_comb begin
        pick     = '{found: 1'b0, eot: 1'b0, kind: KIND_STD};
        pick_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i]) begin
                pick.found = 1'b1;
                pick.eot   = eot_pend[i];
                pick.kind  = (!eot_pend[i] && sel_q[i]) ? KIND_XFER : KIND_STD;
                pick_idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer
    import irq_dispatch_pkg::*;
#(
    parameter int SW   = ST_W,
    parameter int LATE = LATE_WIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_req,
    input  logic          instr_end,
    input  logic [SW-1:0] states_left,
    output logic          fire
);

    ack_state_e state;
    logic       late;

    assign late = (int'(states_left) <= LATE);
    assign fire = (state == ACK_NEXT) && any_req && instr_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ACK_IDLE;
        end else begin
            unique case (state)
                ACK_IDLE: if (any_req) state <= late ? ACK_SKIP : ACK_NEXT;
                ACK_NEXT: if (!any_req || instr_end) state <= ACK_IDLE;
                ACK_SKIP: if (!any_req) state <= ACK_IDLE;
                          else if (instr_end) state <= ACK_NEXT;
                default:  state <= ACK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_dispatch_top.sv
module irq_dispatch_top
    import irq_dispatch_pkg::*;
#(
    parameter int N    = NSRC,
    parameter int CW   = CNT_W,
    parameter int SW   = ST_W,
    parameter int LATE = LATE_WIN,
    localparam int IW  = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_in,
    input  logic [N-1:0]     src_en,
    input  logic             glob_en,
    input  logic             sel_wr,
    input  logic [N-1:0]     sel_wdata,
    input  logic             cnt_wr,
    input  logic [IW-1:0]    cnt_idx,
    input  logic [CW-1:0]    cnt_wdata,
    input  logic             xfer_done,
    input  logic [IW-1:0]    xfer_idx,
    input  logic             instr_end,
    input  logic [SW-1:0]    states_left,
    output logic             disp_valid,
    output logic [IW-1:0]    disp_idx,
    output logic             disp_xfer,
    output logic [VEC_W-1:0] disp_vec,
    output logic [N-1:0]     xsel_q,
    output logic [N-1:0]     eot_q
);

    logic [N-1:0]  req_pend;
    pick_t         pick;
    logic [IW-1:0] pick_idx;
    logic          fire;

    irq_src_bank #(.N(N), .CW(CW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .cnt_wr     (cnt_wr),
        .cnt_idx    (cnt_idx),
        .cnt_wdata  (cnt_wdata),
        .xfer_done  (xfer_done),
        .xfer_idx   (xfer_idx),
        .take_valid (fire),
        .take_idx   (pick_idx),
        .take_eot   (pick.eot),
        .req_pend   (req_pend),
        .eot_pend   (eot_q),
        .sel_q      (xsel_q)
    );

    irq_prio_pick #(.N(N)) u_pick (
        .req_pend (req_pend),
        .eot_pend (eot_q),
        .sel_q    (xsel_q),
        .src_en   (src_en),
        .glob_en  (glob_en),
        .pick     (pick),
        .pick_idx (pick_idx)
    );

    irq_ack_timer #(.SW(SW), .LATE(LATE)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .any_req     (pick.found),
        .instr_end   (instr_end),
        .states_left (states_left),
        .fire        (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_valid <= 1'b0;
            disp_idx   <= '0;
            disp_xfer  <= 1'b0;
            disp_vec   <= '0;
        end else begin
            disp_valid <= fire;
            if (fire) begin
                disp_idx  <= pick_idx;
                disp_xfer <= (pick.kind == KIND_XFER);
                disp_vec  <= vec_of(int'(pick_idx), pick.kind);
            end
        end
    end

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
    import irq_dispatch_pkg::*;
#(
    parameter int N   = NSRC,
    localparam int IW = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_end,
    input logic             glob_en,
    input logic [N-1:0]     src_en,
    input logic             disp_valid,
    input logic [IW-1:0]    disp_idx,
    input logic             disp_xfer,
    input logic [VEC_W-1:0] disp_vec,
    input logic [N-1:0]     xsel_q,
    input logic [N-1:0]     eot_q
);

    // R8: pulse is one cycle long
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !disp_valid);

    // R8: a pulse follows a boundary cycle
    a_r8_on_boundary: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> $past(instr_end));

    // R1: blocked sources are never dispatched
    a_r1_gated: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ($past(glob_en) && $past(src_en[disp_idx])));

    // R3: vector lies in the region that matches the flag
    a_r3_vec_region: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_xfer ? (disp_vec >= XFER_BASE) : (disp_vec < XFER_BASE)));

    // R5: an end-of-transfer bit only rises with transfer service switched off
    for (genvar i = 0; i < N; i++) begin : g_drain
        a_r5_handback: assert property (@(posedge clk) disable iff (rst)
            $rose(eot_q[i]) |-> !xsel_q[i]);
    end

endmodule

bind irq_dispatch_top irq_dispatch_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_end  (instr_end),
    .glob_en    (glob_en),
    .src_en     (src_en),
    .disp_valid (disp_valid),
    .disp_idx   (disp_idx),
    .disp_xfer  (disp_xfer),
    .disp_vec   (disp_vec),
    .xsel_q     (xsel_q),
    .eot_q      (eot_q)
);

// File: tb/irq_dispatch_top_test.sv
`timescale 1ns/1ps
module irq_dispatch_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] req_in, src_en, sel_wdata;
    logic        glob_en, sel_wr, cnt_wr, xfer_done, instr_end;
    logic [3:0]  cnt_idx, xfer_idx, states_left;
    logic [7:0]  cnt_wdata;
    logic        disp_valid, disp_xfer;
    logic [3:0]  disp_idx;
    logic [23:0] disp_vec;
    logic [15:0] xsel_q, eot_q;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] sel_shadow = '0;

    always #2 clk = ~clk;

    irq_dispatch_top uut (
        .clk(clk), .rst(rst), .req_in(req_in), .src_en(src_en), .glob_en(glob_en),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .cnt_wr(cnt_wr), .cnt_idx(cnt_idx),
        .cnt_wdata(cnt_wdata), .xfer_done(xfer_done), .xfer_idx(xfer_idx),
        .instr_end(instr_end), .states_left(states_left), .disp_valid(disp_valid),
        .disp_idx(disp_idx), .disp_xfer(disp_xfer), .disp_vec(disp_vec),
        .xsel_q(xsel_q), .eot_q(eot_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic raise(input int i);
        @(negedge clk); req_in = 16'(1) << i;
        @(negedge clk); req_in = '0;
        @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk); instr_end = 1'b1;
        @(negedge clk); instr_end = 1'b0;
    endtask

    task automatic write_sel(input logic [15:0] v);
        sel_shadow = v;
        @(negedge clk); sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic load_cnt(input int i, input int v);
        @(negedge clk); cnt_wr = 1'b1; cnt_idx = 4'(i); cnt_wdata = 8'(v);
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic strobe(input int i);
        @(negedge clk); xfer_done = 1'b1; xfer_idx = 4'(i);
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic expect_disp(input string tag, input int idx, input bit xf, input logic [23:0] vec);
        chk({tag, " valid"}, 32'(disp_valid), 32'd1);
        chk({tag, " idx"},   32'(disp_idx),   32'(idx));
        chk({tag, " xfer"},  32'(disp_xfer),  32'(xf));
        chk({tag, " vec"},   32'(disp_vec),   32'(vec));
    endtask

    task automatic t_reset();
        chk("R10 disp_valid", 32'(disp_valid), 0);
        chk("R10 xsel_q", 32'(xsel_q), 0);
        chk("R10 eot_q", 32'(eot_q), 0);
    endtask

    task automatic t_basic();
        raise(3);
        repeat (3) begin
            @(negedge clk);
            chk("R8 no dispatch without boundary", 32'(disp_valid), 0);
        end
        boundary();
        expect_disp("R3 R8 ordinary src3", 3, 1'b0, 24'hFF2006);
        @(negedge clk);
        chk("R8 single-cycle pulse", 32'(disp_valid), 0);
    endtask

    task automatic t_priority();
        @(negedge clk); req_in = 16'h0204;
        @(negedge clk); req_in = '0;
        boundary();
        expect_disp("R2 high wins", 9, 1'b0, 24'hFF2012);
        boundary();
        expect_disp("R2 low next", 2, 1'b0, 24'hFF2004);
    endtask

    task automatic t_mask();
        src_en = 16'hFFDF;
        raise(5);
        boundary();
        chk("R1 masked src5 held off", 32'(disp_valid), 0);
        src_en = 16'hFFFF;
        boundary();
        expect_disp("R1 src5 after unmask", 5, 1'b0, 24'hFF200A);
        glob_en = 1'b0;
        raise(7);
        boundary();
        chk("R1 global disable", 32'(disp_valid), 0);
        glob_en = 1'b1;
        boundary();
        expect_disp("R1 src7 after global enable", 7, 1'b0, 24'hFF200E);
    endtask

    task automatic t_transfer_and_drain();
        load_cnt(4, 2);
        write_sel(sel_shadow | 16'h0010);
        chk("R7 select written", 32'(xsel_q[4]), 1);
        raise(4);
        boundary();
        expect_disp("R4 R3 transfer src4", 4, 1'b1, 24'hFF2048);
        strobe(4);
        chk("R5 count 2->1 keeps select", 32'(xsel_q[4]), 1);
        chk("R5 count 2->1 no eot", 32'(eot_q[4]), 0);
        strobe(4);
        chk("R5 count 1->0 clears select", 32'(xsel_q[4]), 0);
        chk("R5 count 1->0 sets eot", 32'(eot_q[4]), 1);
        sel_shadow[4] = 1'b0;
        raise(3);
        boundary();
        expect_disp("R6 eot uses ordinary vector", 4, 1'b0, 24'hFF2008);
        chk("R6 eot cleared on dispatch", 32'(eot_q[4]), 0);
        boundary();
        expect_disp("R6 lower src3 after eot", 3, 1'b0, 24'hFF2006);
    endtask

    task automatic t_reenable();
        write_sel(sel_shadow | 16'h0010);
        load_cnt(4, 1);
        raise(4);
        boundary();
        expect_disp("R7 re-enabled transfer", 4, 1'b1, 24'hFF2048);
        strobe(4);
        chk("R5 count 1 drains at once", 32'(eot_q[4]), 1);
        sel_shadow[4] = 1'b0;
        boundary();
        boundary();
        chk("R6 eot served", 32'(eot_q[4]), 0);
    endtask

    task automatic t_zero_count();
        write_sel(sel_shadow | 16'h0100);
        strobe(8);
        chk("R11 zero count keeps select", 32'(xsel_q[8]), 1);
        chk("R11 zero count no eot", 32'(eot_q[8]), 0);
        write_sel(sel_shadow & ~16'h0100);
    endtask

    task automatic t_late();
        states_left = 4'd4;
        raise(6);
        boundary();
        chk("R9 late arrival skips first boundary", 32'(disp_valid), 0);
        states_left = 4'd10;
        boundary();
        expect_disp("R9 late dispatch on second boundary", 6, 1'b0, 24'hFF200C);
        states_left = 4'd5;
        raise(6);
        boundary();
        expect_disp("R9 on-time at five states", 6, 1'b0, 24'hFF200C);
        states_left = 4'd10;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_in = '0; src_en = 16'hFFFF; glob_en = 1'b1;
        sel_wr = 1'b0; sel_wdata = '0; cnt_wr = 1'b0; cnt_idx = '0; cnt_wdata = '0;
        xfer_done = 1'b0; xfer_idx = '0; instr_end = 1'b0; states_left = 4'd10;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_priority();
        t_mask();
        t_transfer_and_drain();
        t_reenable();
        t_zero_count();
        t_late();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule